// File: doc/BRIEF.md
# Host-Programmed SPI Flash Command Engine

This block is an SPI master driven entirely by a small byte-wide register window. Software loads a command byte and a packed pair of byte counts, pushes up to eight payload bytes into an eight-entry ring buffer through a single data port, and then sets a self-clearing go bit. The engine pulls chip select low and sends the command byte. It then sends the payload bytes, followed by filler bytes for the read phase, and releases chip select. A single transaction runs one complete flash command.

The transmit and receive paths share one ring buffer, and nothing ever clears it. Every byte clocked after the command byte, in both the write phase and the read phase, stores the byte sampled from the data-in line back into the buffer slot for its position. When the command ends, the visible buffer pointer sits just past the last response byte. Software rewinds the pointer, skips the echoed write-phase bytes and reads the response through the same data port. A two-bit field selects one of three serial clock rates.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sck` is low, the command and count registers read 0x00, the control register reads 0x00, and the status register reads 0x10 (pointer 0, clock select 1).
- R2: The command register at offset 0x0 and the count register at offset 0x1 read back what was written. The count register holds the read count in bits 7:4 and the write count in bits 3:0. A nibble written above 8 is stored as 8.
- R3: A write at offset 0xC stores the byte at the current pointer, and a read at 0xC returns the byte at the current pointer. Each access moves the pointer forward by one, modulo 8. The pointer reads back in bits 2:0 of offset 0xD.
- R4: Writing the control register at offset 0x2 with bit 4 set returns the pointer to 0. Writing it with bit 0 set starts a transaction. Bit 0 reads as 1 while a transaction runs and as 0 once it ends.
- R5: A transaction uses SPI mode 0 and sends bits MSB first, with `spi_mosi` changing only while `spi_sck` is low. Exactly 1+W+R bytes are sent: the command byte, then buffer entries 0..W-1, then R bytes of 0xFF.
- R6: For every byte index i (0-based) after the command byte, the byte sampled on `spi_miso` overwrites buffer entry i mod 8. This includes the write-phase bytes.
- R7: When a transaction ends, the pointer equals (W+R) mod 8, whatever its value at start. The read data sits in entries W..W+R-1.
- R8: Bits 5:4 of offset 0xD set the serial half-period to H = 2, 3 or 4 times DIV_UNIT clocks for codes 1, 2 and 3. The reserved code 0 behaves like code 3. Chip select falls H clocks before the first rising `spi_sck` edge. It rises H clocks after the last falling edge.
- R9: While a transaction runs, writes to the command, count, data, control and status registers have no effect. The command, the count and the clock select read back unchanged after completion.
- R10: With W=0 and R=0, only the command byte is sent and the pointer ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the pointer at 0xC) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is a command whose write and read counts sum above eight. In that case the response bytes wrap around the ring and overwrite the earlier echoes, and the final pointer aliases back into the low slots. The bench drives a 4-write, 8-read command with a slave that answers each byte position with a distinct value, then rewinds the pointer and reads the whole ring to confirm which bytes survived. It also starts one command with the pointer deliberately left at 5, and pokes every register in the middle of a command with a write count chosen so that a leaked data write would land in a slot the engine never touches.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIB_W    = 4;

  localparam logic [3:0] OFS_CMD   = 4'h0;
  localparam logic [3:0] OFS_CNT   = 4'h1;
  localparam logic [3:0] OFS_CTL   = 4'h2;
  localparam logic [3:0] OFS_DATA  = 4'hC;
  localparam logic [3:0] OFS_STAT  = 4'hD;

  localparam int unsigned CTL_GO_BIT  = 0;
  localparam int unsigned CTL_RWD_BIT = 4;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_TAIL
  } shift_state_e;

  function automatic logic [NIB_W-1:0] clamp_count(input logic [NIB_W-1:0] v,
                                                   input logic [NIB_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/spi_cmd_ring.sv
module spi_cmd_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_we,
  input  logic                     host_adv,
  input  logic [WIDTH-1:0]         host_wdata,
  input  logic                     ptr_clr,
  input  logic                     eng_we,
  input  logic [$clog2(DEPTH)-1:0] eng_widx,
  input  logic [WIDTH-1:0]         eng_wdata,
  input  logic [$clog2(DEPTH)-1:0] eng_ridx,
  output logic [WIDTH-1:0]         eng_rdata,
  input  logic                     ptr_load,
  input  logic [$clog2(DEPTH)-1:0] ptr_load_val,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic [WIDTH-1:0]         ptr_data
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [WIDTH-1:0] slot [DEPTH];

  // entries carry no reset: contents survive across commands
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             hit_host;
    logic             hit_eng;
    logic [WIDTH-1:0] ent_q;
    assign hit_host = host_we && (ptr_q == PTR_W'(g));
    assign hit_eng  = eng_we && (eng_widx == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (hit_host) begin
        ent_q <= host_wdata;
      end else if (hit_eng) begin
        ent_q <= eng_wdata;
      end
    end
    assign slot[g] = ent_q;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load) begin
      ptr_d = ptr_load_val;
    end else if (ptr_clr) begin
      ptr_d = '0;
    end else if (host_adv) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr       = ptr_q;
  assign ptr_data  = slot[ptr_q];
  assign eng_rdata = slot[eng_ridx];

  // R3: the pointer only steps by one, returns to zero, or takes the end value
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |->
      ((ptr_q == $past(ptr_q) + 1'b1) || (ptr_q == '0) || $past(ptr_load)));

endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int unsigned DIV_UNIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int unsigned HALF_MAX = 4 * DIV_UNIT;
  localparam int unsigned CW       = $clog2(HALF_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] half;

  always_comb begin
    unique case (sel)
      2'd1:    half = CW'(2 * DIV_UNIT);
      2'd2:    half = CW'(3 * DIV_UNIT);
      default: half = CW'(4 * DIV_UNIT);
    endcase
  end

  assign tick = run && (cnt_q == half - 1'b1);

  always_comb begin
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R8: the divider stays parked while no transaction runs
  p_div_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (cnt_q == '0));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BYTE_W-1:0]        opcode,
  input  logic [NIB_W-1:0]         wr_cnt,
  input  logic [NIB_W-1:0]         rd_cnt,
  input  logic                     tick,
  output logic                     busy,
  output logic                     sck,
  output logic                     cs_n,
  output logic                     mosi,
  input  logic                     miso,
  output logic [$clog2(DEPTH)-1:0] buf_ridx,
  input  logic [BYTE_W-1:0]        buf_rdata,
  output logic                     buf_we,
  output logic [$clog2(DEPTH)-1:0] buf_widx,
  output logic [BYTE_W-1:0]        buf_wdata,
  output logic                     ptr_load,
  output logic [$clog2(DEPTH)-1:0] ptr_load_val
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned IDX_W = $clog2(2 * DEPTH + 2);

  shift_state_e       st_q, st_d;
  logic [2:0]         bit_q, bit_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic [BYTE_W-1:0]  rx_q, rx_d;
  logic               sck_q, sck_d;
  logic               csn_q, csn_d;
  logic [IDX_W-1:0]   last_idx;
  logic [BYTE_W-1:0]  next_tx;

  assign last_idx = IDX_W'(wr_cnt) + IDX_W'(rd_cnt);
  assign buf_ridx = idx_q[PTR_W-1:0];
  assign next_tx  = (idx_q < IDX_W'(wr_cnt)) ? buf_rdata : 8'hFF;

  assign buf_widx     = PTR_W'(idx_q - 1'b1);
  assign buf_wdata    = rx_q;
  assign ptr_load_val = last_idx[PTR_W-1:0];

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    idx_d    = idx_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    sck_d    = sck_q;
    csn_d    = csn_q;
    buf_we   = 1'b0;
    ptr_load = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_d  = SH_LOW;
          csn_d = 1'b0;
          tx_d  = opcode;
          bit_d = 3'd7;
          idx_d = '0;
        end
      end
      SH_LOW: begin
        if (tick) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[BYTE_W-2:0], miso};
          st_d  = SH_HIGH;
        end
      end
      SH_HIGH: begin
        if (tick) begin
          sck_d = 1'b0;
          if (bit_q == 3'd0) begin
            buf_we = (idx_q != '0);
            if (idx_q == last_idx) begin
              st_d = SH_TAIL;
            end else begin
              idx_d = idx_q + 1'b1;
              bit_d = 3'd7;
              tx_d  = next_tx;
              st_d  = SH_LOW;
            end
          end else begin
            bit_d = bit_q - 1'b1;
            tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
            st_d  = SH_LOW;
          end
        end
      end
      SH_TAIL: begin
        if (tick) begin
          csn_d    = 1'b1;
          ptr_load = 1'b1;
          tx_d     = 8'hFF;
          st_d     = SH_IDLE;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      bit_q <= 3'd7;
      idx_q <= '0;
      tx_q  <= 8'hFF;
      rx_q  <= '0;
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      sck_q <= sck_d;
      csn_q <= csn_d;
    end
  end

  assign busy = (st_q != SH_IDLE);
  assign sck  = sck_q;
  assign cs_n = csn_q;
  assign mosi = tx_q[BYTE_W-1];

  // R5: the serial clock only pulses inside an asserted chip select
  p_sck_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !csn_q);

  // R5: data out holds still across each high phase of the clock
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(tx_q[BYTE_W-1]));

  // R7: the pointer end value is loaded exactly as chip select releases
  p_load_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> csn_q);

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic                     busy,
  input  logic [$clog2(DEPTH)-1:0] ptr,
  input  logic [BYTE_W-1:0]        ptr_data,
  output logic                     host_we,
  output logic                     host_adv,
  output logic                     ptr_clr,
  output logic                     start,
  output logic [BYTE_W-1:0]        opcode,
  output logic [NIB_W-1:0]         wr_cnt,
  output logic [NIB_W-1:0]         rd_cnt,
  output logic [1:0]               clk_sel
);

  localparam logic [NIB_W-1:0] CNT_LIM = NIB_W'(DEPTH);

  logic [BYTE_W-1:0] opc_q, opc_d;
  logic [BYTE_W-1:0] cnt_q, cnt_d;
  logic [1:0]        sel_q, sel_d;
  logic              wr_ok;

  assign wr_ok = bus_wr && !busy;

  assign host_we  = wr_ok && (bus_addr == OFS_DATA);
  assign host_adv = (bus_wr || bus_rd) && !busy && (bus_addr == OFS_DATA);
  assign ptr_clr  = wr_ok && (bus_addr == OFS_CTL) && bus_wdata[CTL_RWD_BIT];
  assign start    = wr_ok && (bus_addr == OFS_CTL) && bus_wdata[CTL_GO_BIT];

  always_comb begin
    opc_d = opc_q;
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (wr_ok) begin
      unique case (bus_addr)
        OFS_CMD:  opc_d = bus_wdata;
        OFS_CNT:  cnt_d = {clamp_count(bus_wdata[7:4], CNT_LIM),
                           clamp_count(bus_wdata[3:0], CNT_LIM)};
        OFS_STAT: sel_d = bus_wdata[5:4];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
      cnt_q <= '0;
      sel_q <= 2'd1;
    end else begin
      opc_q <= opc_d;
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CMD:  bus_rdata = opc_q;
      OFS_CNT:  bus_rdata = cnt_q;
      OFS_CTL:  bus_rdata = {7'd0, busy};
      OFS_DATA: bus_rdata = ptr_data;
      OFS_STAT: bus_rdata = {2'b00, sel_q, 4'b0000} | BYTE_W'(ptr);
      default:  bus_rdata = '0;
    endcase
  end

  assign opcode  = opc_q;
  assign wr_cnt  = cnt_q[3:0];
  assign rd_cnt  = cnt_q[7:4];
  assign clk_sel = sel_q;

  // R2: neither stored count ever exceeds the buffer depth
  p_count_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[3:0] <= CNT_LIM) && (cnt_q[7:4] <= CNT_LIM));

  // R9: command, counts and rate are frozen for the whole transaction
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(opc_q) && $stable(cnt_q) && $stable(sel_q)));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 8,
  parameter int unsigned DIV_UNIT  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int unsigned PTR_W = $clog2(BUF_DEPTH);

  logic              busy, start, tick;
  logic              host_we, host_adv, ptr_clr;
  logic [BYTE_W-1:0] opcode;
  logic [NIB_W-1:0]  wr_cnt, rd_cnt;
  logic [1:0]        clk_sel;
  logic [PTR_W-1:0]  ptr, eng_ridx, eng_widx, ptr_load_val;
  logic [BYTE_W-1:0] ptr_data, eng_rdata, eng_wdata;
  logic              eng_we, ptr_load;

  spi_cmd_regs #(.DEPTH(BUF_DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .ptr       (ptr),
    .ptr_data  (ptr_data),
    .host_we   (host_we),
    .host_adv  (host_adv),
    .ptr_clr   (ptr_clr),
    .start     (start),
    .opcode    (opcode),
    .wr_cnt    (wr_cnt),
    .rd_cnt    (rd_cnt),
    .clk_sel   (clk_sel)
  );

  spi_cmd_ring #(.DEPTH(BUF_DEPTH), .WIDTH(BYTE_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_we),
    .host_adv     (host_adv),
    .host_wdata   (bus_wdata),
    .ptr_clr      (ptr_clr),
    .eng_we       (eng_we),
    .eng_widx     (eng_widx),
    .eng_wdata    (eng_wdata),
    .eng_ridx     (eng_ridx),
    .eng_rdata    (eng_rdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr          (ptr),
    .ptr_data     (ptr_data)
  );

  spi_cmd_clkdiv #(.DIV_UNIT(DIV_UNIT)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .sel   (clk_sel),
    .tick  (tick)
  );

  spi_cmd_shifter #(.DEPTH(BUF_DEPTH)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .opcode       (opcode),
    .wr_cnt       (wr_cnt),
    .rd_cnt       (rd_cnt),
    .tick         (tick),
    .busy         (busy),
    .sck          (spi_sck),
    .cs_n         (spi_cs_n),
    .mosi         (spi_mosi),
    .miso         (spi_miso),
    .buf_ridx     (eng_ridx),
    .buf_rdata    (eng_rdata),
    .buf_we       (eng_we),
    .buf_widx     (eng_widx),
    .buf_wdata    (eng_wdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val)
  );

  // R4: a start is only ever accepted with chip select released
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> spi_cs_n);

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       miso_r = 1'b1;

  spi_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(miso_r)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 0;

  // reference state kept by the bench
  byte unsigned model_buf [8];
  byte unsigned resp [18];
  byte unsigned cap_q [$];
  int  cur_h = 2;

  // pin monitor state
  bit  prev_sck = 0, prev_cs = 1, prev_mosi = 1, first_rise = 0;
  int  t_cs = 0, t_rise = 0, t_fall = 0, bidx = 0, nbits = 0;
  byte unsigned cap_byte = 0;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog (all reqs): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // behavioural slave and per-clock line checks
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 sck outside frame", int'(spi_sck && spi_cs_n), 0);
      if (spi_sck && prev_sck) chk("R5 mosi moved while sck high", int'(spi_mosi), int'(prev_mosi));
      if (prev_cs && !spi_cs_n) begin
        t_cs = cyc; first_rise = 1; bidx = 0; nbits = 0;
        miso_r = resp[0][7];
      end
      if (!prev_sck && spi_sck) begin
        if (first_rise) begin
          chk("R8 cs fall to first rise", cyc - t_cs, cur_h);
          first_rise = 0;
        end
        t_rise = cyc;
        cap_byte = {cap_byte[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0) cap_q.push_back(cap_byte);
      end
      if (prev_sck && !spi_sck) begin
        chk("R8 sck high time", cyc - t_rise, cur_h);
        t_fall = cyc;
        bidx++;
        if (bidx / 8 < 18) miso_r = resp[bidx / 8][7 - (bidx % 8)];
      end
      if (!prev_cs && spi_cs_n) chk("R8 last fall to cs release", cyc - t_fall, cur_h);
    end
    prev_sck  = spi_sck;
    prev_cs   = spi_cs_n;
    prev_mosi = spi_mosi;
  end

  task automatic bus_write(input logic [3:0] a, input byte unsigned d);
    @(negedge clk);
    #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output byte unsigned d);
    @(negedge clk);
    #1;
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
  endtask

  function automatic int half_of(input int sel);
    return (sel == 0) ? 4 : sel + 1;
  endfunction

  task automatic check_ring(string req);
    byte unsigned v;
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bus_read(4'hC, v);
      chk(req, v, model_buf[i]);
    end
  endtask

  // one full command; poke=1 writes every register while busy
  task automatic run_cmd(input byte unsigned opc, input int w, input int r,
                         input int sel, input bit rewind, input bit poke);
    byte unsigned v;
    byte unsigned pay [8];
    bus_write(4'hD, byte'(sel << 4));
    cur_h = half_of(sel);
    bus_write(4'h0, opc);
    bus_write(4'h1, byte'((r << 4) | w));
    if (rewind) bus_write(4'h2, 8'h10);
    for (int i = 0; i < w; i++) begin
      pay[i] = byte'(opc ^ (i * 37 + 11));
      bus_write(4'hC, pay[i]);
      model_buf[i] = pay[i];
    end
    for (int k = 0; k < 18; k++) resp[k] = byte'((k * 29) ^ 8'hC3 ^ opc);
    cap_q.delete();
    bus_write(4'h2, 8'h01);
    bus_read(4'h2, v);
    chk("R4 busy after go", v, 1);
    if (poke) begin
      bus_write(4'h0, 8'hEE);
      bus_write(4'h1, 8'h11);
      bus_write(4'hC, 8'hAA);
      bus_write(4'h2, 8'h10);
      bus_write(4'hD, 8'h30);
    end
    v = 1;
    while (v != 0) bus_read(4'h2, v);
    chk("R4 go self-clears", v, 0);
    chk("R5 byte count sent", cap_q.size(), 1 + w + r);
    for (int i = 0; i < cap_q.size() && i < 1 + w + r; i++) begin
      if (i == 0) chk("R5 command byte", cap_q[i], opc);
      else if (i <= w) chk("R5 payload byte", cap_q[i], pay[i-1]);
      else chk("R5 read filler", cap_q[i], 8'hFF);
    end
    for (int i = 0; i < w + r; i++) model_buf[i % 8] = resp[i + 1];
    bus_read(4'hD, v);
    chk("R7 end pointer", v & 8'h07, (w + r) % 8);
    chk("R9 clock select kept", (v >> 4) & 3, sel);
    bus_read(4'h1, v);
    chk("R9 count unchanged", v, (r << 4) | w);
    bus_read(4'h0, v);
    chk("R9 command unchanged", v, opc);
    check_ring("R6 ring contents");
  endtask

  initial begin
    byte unsigned v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    bus_read(4'h0, v); chk("R1 command reset", v, 0);
    bus_read(4'h1, v); chk("R1 count reset", v, 0);
    bus_read(4'h2, v); chk("R1 control reset", v, 0);
    bus_read(4'hD, v); chk("R1 status reset", v, 8'h10);
    chk("R1 cs idle", int'(spi_cs_n), 1);
    chk("R1 sck idle", int'(spi_sck), 0);

    // R3 data port fill and wrap
    for (int i = 0; i < 8; i++) begin
      model_buf[i] = byte'(8'h40 + i * 3);
      bus_write(4'hC, model_buf[i]);
      bus_read(4'hD, v);
      chk("R3 pointer step", v & 7, (i + 1) % 8);
    end
    for (int i = 0; i < 8; i++) begin
      bus_read(4'hC, v);
      chk("R3 data port readback", v, model_buf[i]);
    end
    bus_read(4'hC, v);
    bus_read(4'hC, v);
    bus_write(4'h2, 8'h10);
    bus_read(4'hD, v);
    chk("R4 pointer rewind", v & 7, 0);

    // R2 register readback and saturation
    bus_write(4'h0, 8'h5A); bus_read(4'h0, v); chk("R2 command readback", v, 8'h5A);
    bus_write(4'h1, 8'hFA); bus_read(4'h1, v); chk("R2 count saturates", v, 8'h88);
    bus_write(4'h1, 8'h35); bus_read(4'h1, v); chk("R2 count packing", v, 8'h35);

    // R5 R6 R7 R8 across shapes and rates
    run_cmd(8'h9F, 0, 3, 1, 1, 0);
    run_cmd(8'h03, 3, 5, 2, 1, 0);
    run_cmd(8'h02, 8, 0, 3, 1, 0);
    run_cmd(8'h0B, 4, 8, 0, 1, 0);   // wraps the ring, reserved rate code

    // R10 bare command started with the pointer at 5
    for (int i = 0; i < 5; i++) bus_read(4'hC, v);
    bus_read(4'hD, v);
    chk("R10 pointer preset", v & 7, 5);
    run_cmd(8'h06, 0, 0, 1, 0, 0);

    // R9 writes while busy are ignored
    run_cmd(8'h20, 2, 0, 2, 1, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule